// File: doc/BRIEF.md
# GHASH Accumulator with Length Finalization

This block keeps the running GHASH value used for authentication in Galois/Counter Mode. Each 128-bit block presented on the data port is folded into the running value Y as Y = (Y XOR X) * H over GF(2^128), where H is a hash key supplied from outside. A bit-serial multiplier does each product, one bit per clock. A block may carry fewer than sixteen valid bytes. The missing trailing bytes are forced to zero before the block is folded in, so a short final block of associated data or text needs no padding by the caller.

A hash can be split over several passes. While a pass is still fresh (nothing absorbed since the last clear or close), a preset port may overwrite Y with an intermediate value saved from an earlier pass. A separate close request folds in the length block. That block is formed from two byte counts held on their own ports, the associated-data count and the text count, and the text count may be zero for a hash-only pass. A done flag then marks the final tag input. Y is read back one 32-bit word at a time.

The controller has three states. In ST_IDLE the block can accept a clear, a preset, a data block or a close request. ST_ABSORB multiplies a data block. ST_CLOSE multiplies the length block. The transitions are:
- IDLE to ABSORB on an accepted block.
- IDLE to CLOSE on an accepted close request.
- ABSORB or CLOSE back to IDLE when the multiplier finishes, or at once on a clear.

Top module: `ghash_accum`

## Requirements
- R1: Each accepted block X updates Y to (Y XOR X) * H. Bit 127 of a port vector is the first (most significant) GCM bit, and reduction uses x^128 + x^7 + x^2 + x + 1.
- R2: `in_bytes` gives the number of valid leading bytes, where byte k occupies bits [127-8k:120-8k]. Bytes at index `in_bytes` and above are replaced by zero before absorption. A value of 0 or of 16 or more means all sixteen bytes are valid.
- R3: `in_ready` drops at the edge that accepts a block or close request and stays low for 129 cycles (128 multiply steps plus one write-back). A block is accepted only on a cycle where `in_ready` is high.
- R4: A preset on `ld_valid` replaces Y with `ld_value` only while the pass is fresh, meaning no block has been absorbed since reset, clear or close. Otherwise the preset is ignored and Y keeps its value. A preset takes priority over a block offered in the same cycle.
- R5: A `clr` cycle sets Y to zero, clears `done`, makes the pass fresh and abandons any multiply in progress.
- R6: A close request (`len_go` with no block offered) absorbs the block {64-bit aad_bytes*8, 64-bit txt_bytes*8}, with the associated-data count in the upper half.
- R7: `done` rises when the close multiply writes back. It stays high until a clear, an accepted preset or an accepted block.
- R8: `rd_word` shows word `rd_sel` of Y, where word 0 is bits [127:96] and word 3 is bits [31:0].
- R9: After reset, Y is zero, `done` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of the running hash |
| hkey | input | 128 | Hash key H, sampled when a multiply starts |
| ld_valid | input | 1 | Preset request |
| ld_value | input | 128 | Preset value for Y |
| in_valid | input | 1 | Data block offered |
| in_data | input | 128 | Data block, first byte in bits [127:120] |
| in_bytes | input | 5 | Count of valid leading bytes (0 means 16) |
| in_ready | output | 1 | Block or close request can be accepted |
| len_go | input | 1 | Close request: absorb the length block |
| aad_bytes | input | 32 | Associated-data byte count |
| txt_bytes | input | 32 | Text byte count |
| done | output | 1 | Closed hash is ready |
| rd_sel | input | 2 | Word select for readback |
| rd_word | output | 32 | Selected 32-bit word of Y |

## Verification
The bench builds the block with its default parameters: a 128-bit block, 32-bit length counts and the standard reduction constant. These values make the exact GCM product reachable, so every result is compared against a product computed independently in the bench. The length counts are wide enough to check non-trivial bit counts in both halves of the closing block. With 16-byte blocks, every partial-byte boundary can be reached, from a single valid byte up to the treatment of 0 as a full block.

// File: rtl/ghash_pkg.sv
package ghash_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ABSORB = 2'd1,
        ST_CLOSE  = 2'd2
    } ghash_state_t;

endpackage

// File: rtl/ghash_pad.sv
module ghash_pad #(
    parameter int W = 128
) (
    input  logic [W-1:0]           raw,
    input  logic [$clog2(W/8):0]   nbytes,
    output logic [W-1:0]           padded
);
    localparam int NB  = W / 8;
    localparam int NBW = $clog2(NB) + 1;

    logic full;
    assign full = (nbytes == '0) || (nbytes >= NBW'(NB));

    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic keep;
        assign keep = full || (NBW'(k) < nbytes);
        assign padded[W-1-8*k -: 8] = keep ? raw[W-1-8*k -: 8] : 8'h00;
    end
endmodule

// File: rtl/gf_mul_serial.sv
module gf_mul_serial #(
    parameter int         W    = 128,
    parameter logic [7:0] POLY = 8'hE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort,
    input  logic         start,
    input  logic [W-1:0] x,
    input  logic [W-1:0] h,
    output logic         busy,
    output logic [W-1:0] z
);
    localparam int         CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [W-1:0]  RED  = {POLY, {(W-8){1'b0}}};

    logic [W-1:0]  x_q;
    logic [W-1:0]  v_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            x_q   <= '0;
            v_q   <= '0;
            z     <= '0;
            cnt_q <= '0;
        end else if (abort) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            x_q   <= x;
            v_q   <= h;
            z     <= '0;
            cnt_q <= '0;
        end else if (busy) begin
            if (x_q[W-1]) begin
                z <= z ^ v_q;
            end
            x_q   <= x_q << 1;
            v_q   <= (v_q >> 1) ^ (v_q[0] ? RED : '0);
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ghash_accum.sv
module ghash_accum #(
    parameter int         W    = 128,
    parameter int         LENW = 32,
    parameter logic [7:0] POLY = 8'hE1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [W-1:0]         hkey,
    input  logic                 ld_valid,
    input  logic [W-1:0]         ld_value,
    input  logic                 in_valid,
    input  logic [W-1:0]         in_data,
    input  logic [$clog2(W/8):0] in_bytes,
    output logic                 in_ready,
    input  logic                 len_go,
    input  logic [LENW-1:0]      aad_bytes,
    input  logic [LENW-1:0]      txt_bytes,
    output logic                 done,
    input  logic [$clog2(W/32)-1:0] rd_sel,
    output logic [31:0]          rd_word
);
    import ghash_pkg::*;

    localparam int HALF = W / 2;

    ghash_state_t st_q, st_d;

    logic [W-1:0] y_q;
    logic [W-1:0] padded;
    logic [W-1:0] lenblk;
    logic [W-1:0] mul_x;
    logic [W-1:0] mul_z;
    logic         mul_busy;
    logic         mul_start;
    logic         fresh_q;
    logic         done_q;
    logic         is_idle;
    logic         ld_take;
    logic         blk_take;
    logic         len_take;
    logic         finish;

    ghash_pad #(.W(W)) u_pad (
        .raw    (in_data),
        .nbytes (in_bytes),
        .padded (padded)
    );

    gf_mul_serial #(.W(W), .POLY(POLY)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (clr),
        .start (mul_start),
        .x     (mul_x),
        .h     (hkey),
        .busy  (mul_busy),
        .z     (mul_z)
    );

    assign lenblk = {HALF'({aad_bytes, 3'b000}), HALF'({txt_bytes, 3'b000})};

    // handshake and datapath selects
    always_comb begin
        is_idle   = (st_q == ST_IDLE);
        ld_take   = is_idle && !clr && ld_valid && fresh_q;
        in_ready  = is_idle && !clr && !ld_take;
        blk_take  = in_ready && in_valid;
        len_take  = in_ready && !in_valid && len_go;
        mul_start = blk_take || len_take;
        mul_x     = blk_take ? (y_q ^ padded) : (y_q ^ lenblk);
        finish    = !is_idle && !mul_busy;
        done      = done_q;
        rd_word   = y_q[(W-1) - 32*int'(rd_sel) -: 32];
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (blk_take)      st_d = ST_ABSORB;
                else if (len_take) st_d = ST_CLOSE;
            end
            ST_ABSORB, ST_CLOSE: begin
                if (clr || !mul_busy) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q     <= '0;
            done_q  <= 1'b0;
            fresh_q <= 1'b1;
        end else if (clr) begin
            y_q     <= '0;
            done_q  <= 1'b0;
            fresh_q <= 1'b1;
        end else begin
            if (ld_take) begin
                y_q    <= ld_value;
                done_q <= 1'b0;
            end
            if (blk_take) begin
                fresh_q <= 1'b0;
                done_q  <= 1'b0;
            end
            if (finish) begin
                y_q <= mul_z;
                if (st_q == ST_CLOSE) begin
                    done_q  <= 1'b1;
                    fresh_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ghash_accum_chk.sv
module ghash_accum_chk #(
    parameter int W = 128
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         ld_valid,
    input logic         in_valid,
    input logic         in_ready,
    input logic         len_go,
    input logic         done,
    input logic [W-1:0] y_q,
    input logic         fresh_q,
    input logic         mul_busy,
    input logic         is_idle
);
    p_ready_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mul_busy);

    p_accept_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (y_q == '0 && !done && fresh_q));

    p_load_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !fresh_q && is_idle && !clr && !in_valid && !len_go) |=> $stable(y_q));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr && !ld_valid && !(in_valid && in_ready)) |=> done);
endmodule

bind ghash_accum ghash_accum_chk #(.W(W)) u_chk (.*);

// File: tb/ghash_accum_test.sv
`timescale 1ns/1ps
module ghash_accum_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic [127:0] hkey = '0;
    logic         ld_valid = 1'b0;
    logic [127:0] ld_value = '0;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic [4:0]   in_bytes = '0;
    logic         in_ready;
    logic         len_go = 1'b0;
    logic [31:0]  aad_bytes = '0;
    logic [31:0]  txt_bytes = '0;
    logic         done;
    logic [1:0]   rd_sel = '0;
    logic [31:0]  rd_word;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ghash_accum uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hkey(hkey),
        .ld_valid(ld_valid), .ld_value(ld_value),
        .in_valid(in_valid), .in_data(in_data), .in_bytes(in_bytes),
        .in_ready(in_ready), .len_go(len_go),
        .aad_bytes(aad_bytes), .txt_bytes(txt_bytes),
        .done(done), .rd_sel(rd_sel), .rd_word(rd_word)
    );

    // table: {H, data block, valid bytes}
    localparam logic [260:0] VEC [0:5] = '{
        {128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 128'h0388dace60b6a392f328c2b971b2fe78, 5'd16},
        {128'h80000000000000000000000000000000, 128'h0123456789abcdeffedcba9876543210, 5'd16},
        {128'hb83b533708bf535d0aa6e52980d53b78, 128'h42831ec2217774244b7221b784d0d49c, 5'd5},
        {128'hb83b533708bf535d0aa6e52980d53b78, 128'hffffffffffffffffffffffffffffffff, 5'd0},
        {128'hacbef20579b4b8ebce889bac8732dad7, 128'hd9313225f88406e5a55909c5aff5269a, 5'd1},
        {128'h00000000000000000000000000000000, 128'h5a5a5a5a5a5a5a5a5a5a5a5a5a5a5a5a, 5'd16}
    };

    // reference GF(2^128) product, GCM bit order
    function automatic logic [127:0] gf_ref(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] acc = '0;
        logic [127:0] sh = b;
        for (int i = 0; i < 128; i++) begin
            if (a[127 - i]) acc = acc ^ sh;
            if (sh[0]) sh = (sh >> 1) ^ {8'he1, 120'h0};
            else       sh = sh >> 1;
        end
        return acc;
    endfunction

    function automatic logic [127:0] pad_ref(input logic [127:0] d, input int n);
        logic [127:0] r = d;
        if (n == 0 || n >= 16) return d;
        for (int b = n; b < 16; b++) r[127 - 8*b -: 8] = 8'h00;
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_hash(output logic [127:0] v);
        v = '0;
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #0.5;
            v[127 - 32*s -: 32] = rd_word;
        end
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    task automatic send_block(input logic [127:0] d, input int n, output int lowcnt);
        wait_ready();
        in_data  = d;
        in_bytes = 5'(n);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lowcnt = 0;
        while (!in_ready) begin
            lowcnt++;
            @(negedge clk);
        end
    endtask

    task automatic preset(input logic [127:0] v);
        wait_ready();
        ld_value = v;
        ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic close_hash(input int aad, input int txt);
        wait_ready();
        aad_bytes = 32'(aad);
        txt_bytes = 32'(txt);
        len_go = 1'b1;
        @(negedge clk);
        len_go = 1'b0;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] got, y, h0, p;
        int lc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        read_hash(got);
        chk("R9 hash after reset", got, '0);
        chk("R9 ready after reset", 128'(in_ready), 128'd1);
        chk("R9 done after reset", 128'(done), 128'd0);

        // R1 R2: table walk, one block from a cleared state each
        for (int i = 0; i < 6; i++) begin
            pulse_clr();
            hkey = VEC[i][260:133];
            send_block(VEC[i][132:5], int'(VEC[i][4:0]), lc);
            read_hash(got);
            chk("R1 R2 table product", got,
                gf_ref(pad_ref(VEC[i][132:5], int'(VEC[i][4:0])), VEC[i][260:133]));
        end

        // R1 R3: two chained blocks, ready-low window
        h0 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
        hkey = h0;
        pulse_clr();
        send_block(128'h0388dace60b6a392f328c2b971b2fe78, 16, lc);
        chk("R3 ready low cycles", 128'(lc), 128'd129);
        send_block(128'h1122334455667788_99aabbccddeeff00, 16, lc);
        y = gf_ref(gf_ref(128'h0388dace60b6a392f328c2b971b2fe78, h0)
                   ^ 128'h1122334455667788_99aabbccddeeff00, h0);
        read_hash(got);
        chk("R1 chained blocks", got, y);

        // R6 R7: close with associated data only
        close_hash(20, 0);
        y = gf_ref(y ^ {64'd160, 64'd0}, h0);
        read_hash(got);
        chk("R6 close aad only", got, y);
        chk("R7 done after close", 128'(done), 128'd1);
        repeat (5) @(negedge clk);
        chk("R7 done holds while idle", 128'(done), 128'd1);

        // R4 R7: preset allowed after close, clears done
        p = 128'h00112233445566778899aabbccddeeff;
        preset(p);
        read_hash(got);
        chk("R4 preset after close", got, p);
        chk("R7 done cleared by preset", 128'(done), 128'd0);

        // R8: word order
        rd_sel = 2'd0; #0.5;
        chk("R8 word0", 128'(rd_word), 128'h00112233);
        rd_sel = 2'd3; #0.5;
        chk("R8 word3", 128'(rd_word), 128'hccddeeff);

        // R4: resume from preset, later preset ignored
        send_block(128'hcafebabe_deadbeef_01020304_05060708, 16, lc);
        y = gf_ref(p ^ 128'hcafebabe_deadbeef_01020304_05060708, h0);
        read_hash(got);
        chk("R4 resume from preset", got, y);
        preset(128'hffff0000ffff0000ffff0000ffff0000);
        @(negedge clk);
        read_hash(got);
        chk("R4 preset ignored after block", got, y);

        // R2 R6: partial text block then close with both counts
        send_block(128'habcdef01_23456789_abcdef01_23456789, 9, lc);
        y = gf_ref(y ^ pad_ref(128'habcdef01_23456789_abcdef01_23456789, 9), h0);
        close_hash(16, 25);
        y = gf_ref(y ^ {64'd128, 64'd200}, h0);
        read_hash(got);
        chk("R6 close with text", got, y);

        // R7: accepted block clears done
        send_block(128'h1, 16, lc);
        chk("R7 done cleared by block", 128'(done), 128'd0);

        // R5: clear mid-multiply
        wait_ready();
        in_data = 128'h77; in_bytes = 5'd16; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        pulse_clr();
        read_hash(got);
        chk("R5 hash zero after clear", got, '0);
        chk("R5 ready after clear", 128'(in_ready), 128'd1);
        repeat (140) @(negedge clk);
        read_hash(got);
        chk("R5 aborted multiply leaves zero", got, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule